// File: doc/BRIEF.md
# Hyperbar Delta Circuit Network

This block connects N single-word ports to N single-word ports through a multistage delta network with log2(N) stages. Each stage is built from 2x2 hyperbar switching elements whose output links are thick: every link holds up to two words side by side. A converter at each source widens the port onto a thick link. A converter at each destination narrows the thick link back to one word. The link order between stages is a perfect shuffle, and every element steers a request by one bit of its destination index, most significant bit first.

Each source presents a valid flag, a destination index and a data word. While the setup strobe is high, the network resolves all requests combinationally. At that clock edge every element latches which input lane feeds each of its output lanes. These circuits stay in place until a release strobe clears them. While they are held, words flow forward from source to destination. Each destination also returns a word along the same path to its source. A source learns from its grant flag whether its full path was built. Requests that lose capacity are dropped and the compatible ones still open. Scheduling further passes is the caller's job.

Top module: `hyperbar_delta_net`

## Requirements
- R1: After reset no grant and no destination-valid flag is set, and both data output buses are zero.
- R2: At the edge where setup_i is high, a valid request from source s to destination d is routed by shuffle-then-steer stages on bits d[LG-1] down to d[0]. If its path is built, grant_o[s] and dst_valid_o[d] are 1, and fwd_data_o[d] tracks the live fwd_data_i[s].
- R3: For a granted source s with destination d, bwd_data_o[s] equals the live bwd_data_i[d]. For every source without a grant, bwd_data_o[s] is zero.
- R4: Each thick output link of an element carries at most two requests. When more than two requests want one link, the two with the lowest source index pass and the rest are dropped with no grant.
- R5: A destination accepts one word. Of the requests that reach it, the one with the lowest source index is kept and any second one is refused and gets no grant.
- R6: The number of set grant flags always equals the number of set destination-valid flags.
- R7: Without a strobe, grants, destination flags and the selected routes stay unchanged even when the request inputs change. A new setup_i replaces the circuits using the requests present at that edge.
- R8: A release_i edge clears every circuit, so grants and destination flags drop to zero. When release_i and setup_i are high together, the release wins.
- R9: A source with req_valid_i low never gets a grant and takes no link capacity from other requests.
- R10: A destination that no circuit reaches shows dst_valid_o low and fwd_data_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all circuits |
| setup_i | input | 1 | Latch the routes resolved from the current requests |
| release_i | input | 1 | Clear all held circuits |
| req_valid_i | input | N_PORTS | Per-source request flag |
| req_dest_i | input | N_PORTS*LG | Per-source destination index, source s at bits [s*LG +: LG] |
| fwd_data_i | input | N_PORTS*DW | Per-source word sent forward |
| grant_o | output | N_PORTS | Per-source flag: full path established |
| bwd_data_o | output | N_PORTS*DW | Per-source word returned from its destination |
| dst_valid_o | output | N_PORTS | Per-destination flag: reached by a circuit |
| fwd_data_o | output | N_PORTS*DW | Per-destination word received |
| bwd_data_i | input | N_PORTS*DW | Per-destination word sent back |

## Verification
Routing is exercised with several directed patterns:
- The identity and bit-reversal permutations show that the shuffle and steering order is right.
- Every source aimed at one destination drives the two-lane limit at each stage and the single-word limit at the end.
- A lone request checks one path.
- Invalid low-index sources that aim at contested destinations show that idle requests take no capacity.

Random patterns with destinations drawn from a narrow set create uneven contention at every stage. A model that follows each request's position tells a correct lowest-index priority apart from any other tie order. Changing the inputs between strobes separates held circuits from live data. Raising both strobes together shows which one has priority.

// File: rtl/hbn_pkg.sv
package hbn_pkg;

  // Index of the previous-boundary link that feeds link p after a perfect
  // shuffle over lg address bits (rotate right by one).
  function automatic int rotr_idx(input int p, input int lg);
    return (p >> 1) | ((p & 1) << (lg - 1));
  endfunction

endpackage

// File: rtl/hbn_thin2thick.sv
module hbn_thin2thick #(
  parameter int LG     = 3,
  parameter int DW     = 8,
  parameter int SRC_ID = 0,
  localparam int RW    = 1 + 2 * LG,
  localparam int DLW   = 1 + DW
) (
  input  logic             req_valid_i,
  input  logic [LG-1:0]    req_dest_i,
  input  logic [DW-1:0]    fwd_data_i,
  output logic [2*RW-1:0]  rq_o,
  output logic [2*DLW-1:0] fw_o,
  input  logic [2*DLW-1:0] bk_i,
  output logic             grant_o,
  output logic [DW-1:0]    bwd_data_o
);

  // The port occupies lane 0; lane 1 of the entry link stays empty.
  assign rq_o = {{RW{1'b0}}, req_valid_i, req_dest_i, LG'(SRC_ID)};
  assign fw_o = {{DLW{1'b0}}, 1'b1, fwd_data_i};

  // Narrow the returning thick link: either lane may carry the answer.
  assign grant_o    = bk_i[DLW-1] | bk_i[2*DLW-1];
  assign bwd_data_o = bk_i[DW-1:0] | bk_i[DLW +: DW];

endmodule

// File: rtl/hbn_thick2thin.sv
module hbn_thick2thin #(
  parameter int LG     = 3,
  parameter int DW     = 8,
  parameter int DST_ID = 0,
  localparam int RW    = 1 + 2 * LG,
  localparam int DLW   = 1 + DW
) (
  input  logic [2*RW-1:0]  rq_i,
  input  logic [2*DLW-1:0] fw_i,
  output logic [2*DLW-1:0] bk_o,
  input  logic [DW-1:0]    bwd_data_i,
  output logic             dst_valid_o,
  output logic [DW-1:0]    fwd_data_o,
  output logic             arrive_o,
  output logic             refuse_o,
  output logic             misroute_o,
  output logic             order_bad_o,
  output logic             spill_o
);

  logic          v0, v1;
  logic [LG-1:0] d0, d1, s0, s1;

  assign v0 = rq_i[RW-1];
  assign v1 = rq_i[2*RW-1];
  assign d0 = rq_i[LG +: LG];
  assign d1 = rq_i[RW + LG +: LG];
  assign s0 = rq_i[0 +: LG];
  assign s1 = rq_i[RW +: LG];

  // Setup-time events: lane 0 is kept, a word on lane 1 is refused.
  assign arrive_o    = v0;
  assign refuse_o    = v1;
  assign misroute_o  = (v0 && d0 != LG'(DST_ID)) || (v1 && d1 != LG'(DST_ID));
  assign order_bad_o = v0 && v1 && (s1 < s0);

  // Held circuits: only lane 0 is delivered to the thin port.
  assign dst_valid_o = fw_i[DLW-1];
  assign fwd_data_o  = fw_i[DW-1:0];
  assign spill_o     = fw_i[2*DLW-1];

  // The return word always enters on lane 0; the element gates it by state.
  assign bk_o = {{DLW{1'b0}}, 1'b1, bwd_data_i};

endmodule

// File: rtl/hbn_hyperbar.sv
module hbn_hyperbar #(
  parameter int LG    = 3,
  parameter int DW    = 8,
  parameter int STAGE = 0,
  localparam int RW   = 1 + 2 * LG,
  localparam int DLW  = 1 + DW,
  localparam int BIT  = LG - 1 - STAGE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_i,
  input  logic             release_i,
  input  logic [4*RW-1:0]  rq_i,
  output logic [4*RW-1:0]  rq_o,
  input  logic [4*DLW-1:0] fw_i,
  output logic [4*DLW-1:0] fw_o,
  input  logic [4*DLW-1:0] bk_i,
  output logic [4*DLW-1:0] bk_o
);

  logic [3:0]    vl, bt, win;
  logic [LG-1:0] sr [4];
  logic [2:0]    rk [4];
  logic [3:0]    nv;
  logic [1:0]    ns [4];
  logic [3:0]    st_v;
  logic [1:0]    st_s [4];

  // Setup arbitration: rank each input lane among those bound for the same
  // thick output link; the two lowest source indices take lanes 0 and 1.
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      vl[c] = rq_i[c*RW + RW - 1];
      sr[c] = rq_i[c*RW +: LG];
      bt[c] = rq_i[c*RW + LG + BIT];
    end
    for (int c = 0; c < 4; c++) begin
      rk[c] = 3'd0;
      for (int t = 0; t < 4; t++) begin
        if (t != c && vl[t] && bt[t] == bt[c] && sr[t] < sr[c])
          rk[c] = rk[c] + 3'd1;
      end
      win[c] = vl[c] && (rk[c] < 3'd2);
    end
    rq_o = '0;
    nv   = '0;
    for (int o = 0; o < 4; o++) begin
      ns[o] = 2'd0;
      for (int c = 0; c < 4; c++) begin
        if (win[c] && bt[c] == 1'(o / 2) && rk[c][0] == 1'(o % 2)) begin
          rq_o[o*RW +: RW] = rq_i[c*RW +: RW];
          nv[o] = 1'b1;
          ns[o] = 2'(c);
        end
      end
    end
  end

  // Held routing state per output lane.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= '0;
      for (int o = 0; o < 4; o++) st_s[o] <= 2'd0;
    end else if (release_i) begin
      st_v <= '0;
    end else if (setup_i) begin
      st_v <= nv;
      for (int o = 0; o < 4; o++) st_s[o] <= ns[o];
    end
  end

  // Circuit traffic in both directions over the held selections.
  always_comb begin
    fw_o = '0;
    bk_o = '0;
    for (int o = 0; o < 4; o++) begin
      if (st_v[o]) fw_o[o*DLW +: DLW] = fw_i[st_s[o]*DLW +: DLW];
    end
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 4; o++) begin
        if (st_v[o] && st_s[o] == 2'(c)) bk_o[c*DLW +: DLW] = bk_i[o*DLW +: DLW];
      end
    end
  end

endmodule

// File: rtl/hyperbar_delta_net.sv
module hyperbar_delta_net #(
  parameter int N_PORTS = 8,
  parameter int DW      = 8,
  localparam int LG     = $clog2(N_PORTS),
  localparam int STAGES = LG,
  localparam int EPS    = N_PORTS / 2,
  localparam int LANES  = 2 * N_PORTS,
  localparam int RW     = 1 + 2 * LG,
  localparam int DLW    = 1 + DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  setup_i,
  input  logic                  release_i,
  input  logic [N_PORTS-1:0]    req_valid_i,
  input  logic [N_PORTS*LG-1:0] req_dest_i,
  input  logic [N_PORTS*DW-1:0] fwd_data_i,
  output logic [N_PORTS-1:0]    grant_o,
  output logic [N_PORTS*DW-1:0] bwd_data_o,
  output logic [N_PORTS-1:0]    dst_valid_o,
  output logic [N_PORTS*DW-1:0] fwd_data_o,
  input  logic [N_PORTS*DW-1:0] bwd_data_i
);

  logic [LANES*RW-1:0]  rq_b  [STAGES+1];
  logic [LANES*RW-1:0]  rq_sh [STAGES];
  logic [LANES*DLW-1:0] fw_b  [STAGES+1];
  logic [LANES*DLW-1:0] fw_sh [STAGES];
  logic [LANES*DLW-1:0] bk_b  [STAGES+1];
  logic [LANES*DLW-1:0] bk_sh [STAGES];

  // Named events for the checker.
  logic [N_PORTS-1:0] arrive_w, refuse_w, misroute_w, order_bad_w, spill_w;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_src
    hbn_thin2thick #(.LG(LG), .DW(DW), .SRC_ID(p)) u_in (
      .req_valid_i (req_valid_i[p]),
      .req_dest_i  (req_dest_i[p*LG +: LG]),
      .fwd_data_i  (fwd_data_i[p*DW +: DW]),
      .rq_o        (rq_b[0][p*2*RW +: 2*RW]),
      .fw_o        (fw_b[0][p*2*DLW +: 2*DLW]),
      .bk_i        (bk_b[0][p*2*DLW +: 2*DLW]),
      .grant_o     (grant_o[p]),
      .bwd_data_o  (bwd_data_o[p*DW +: DW])
    );
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar q = 0; q < N_PORTS; q++) begin : g_shuf
      localparam int FROM = hbn_pkg::rotr_idx(q, LG);
      assign rq_sh[s][q*2*RW +: 2*RW]    = rq_b[s][FROM*2*RW +: 2*RW];
      assign fw_sh[s][q*2*DLW +: 2*DLW]  = fw_b[s][FROM*2*DLW +: 2*DLW];
      assign bk_b[s][FROM*2*DLW +: 2*DLW] = bk_sh[s][q*2*DLW +: 2*DLW];
    end
    for (genvar e = 0; e < EPS; e++) begin : g_elem
      hbn_hyperbar #(.LG(LG), .DW(DW), .STAGE(s)) u_hb (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_i   (setup_i),
        .release_i (release_i),
        .rq_i      (rq_sh[s][e*4*RW +: 4*RW]),
        .rq_o      (rq_b[s+1][e*4*RW +: 4*RW]),
        .fw_i      (fw_sh[s][e*4*DLW +: 4*DLW]),
        .fw_o      (fw_b[s+1][e*4*DLW +: 4*DLW]),
        .bk_i      (bk_b[s+1][e*4*DLW +: 4*DLW]),
        .bk_o      (bk_sh[s][e*4*DLW +: 4*DLW])
      );
    end
  end

  for (genvar d = 0; d < N_PORTS; d++) begin : g_dst
    hbn_thick2thin #(.LG(LG), .DW(DW), .DST_ID(d)) u_out (
      .rq_i        (rq_b[STAGES][d*2*RW +: 2*RW]),
      .fw_i        (fw_b[STAGES][d*2*DLW +: 2*DLW]),
      .bk_o        (bk_b[STAGES][d*2*DLW +: 2*DLW]),
      .bwd_data_i  (bwd_data_i[d*DW +: DW]),
      .dst_valid_o (dst_valid_o[d]),
      .fwd_data_o  (fwd_data_o[d*DW +: DW]),
      .arrive_o    (arrive_w[d]),
      .refuse_o    (refuse_w[d]),
      .misroute_o  (misroute_w[d]),
      .order_bad_o (order_bad_w[d]),
      .spill_o     (spill_w[d])
    );
  end

endmodule

// File: rtl/hyperbar_delta_chk.sv
module hyperbar_delta_chk #(
  parameter int N_PORTS = 8,
  parameter int DW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  setup_i,
  input logic                  release_i,
  input logic [N_PORTS-1:0]    req_valid_i,
  input logic [N_PORTS-1:0]    grant_o,
  input logic [N_PORTS-1:0]    dst_valid_o,
  input logic [N_PORTS*DW-1:0] fwd_data_o,
  input logic [N_PORTS-1:0]    arrive_w,
  input logic [N_PORTS-1:0]    refuse_w,
  input logic [N_PORTS-1:0]    misroute_w,
  input logic [N_PORTS-1:0]    order_bad_w,
  input logic [N_PORTS-1:0]    spill_w
);

  logic [N_PORTS*DW-1:0] quiet_mask;
  always_comb begin
    for (int d = 0; d < N_PORTS; d++) quiet_mask[d*DW +: DW] = {DW{!dst_valid_o[d]}};
  end

  // R2
  no_misroute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_i |-> misroute_w == '0);

  // R5
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_i |-> ((refuse_w & ~arrive_w) == '0 && order_bad_w == '0));

  // R5
  spill_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_w & ~dst_valid_o) == '0);

  // R6
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == $countones(dst_valid_o));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_i && !release_i) |=> ($stable(grant_o) && $stable(dst_valid_o)));

  // R8
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (grant_o == '0 && dst_valid_o == '0));

  // R9
  idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_i && !release_i) |=> (grant_o & ~$past(req_valid_i)) == '0);

  // R10
  quiet_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_data_o & quiet_mask) == '0);

endmodule

bind hyperbar_delta_net hyperbar_delta_chk #(.N_PORTS(N_PORTS), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_i     (setup_i),
  .release_i   (release_i),
  .req_valid_i (req_valid_i),
  .grant_o     (grant_o),
  .dst_valid_o (dst_valid_o),
  .fwd_data_o  (fwd_data_o),
  .arrive_w    (arrive_w),
  .refuse_w    (refuse_w),
  .misroute_w  (misroute_w),
  .order_bad_w (order_bad_w),
  .spill_w     (spill_w)
);

// File: tb/test_hyperbar_delta_net.sv
module test_hyperbar_delta_net;
  localparam int  N  = 8;
  localparam int  DW = 8;
  localparam int  LG = 3;
  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_i = 1'b0;
  logic release_i = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*LG-1:0] req_dest = '0;
  logic [N*DW-1:0] fwd_in = '0;
  logic [N*DW-1:0] bwd_in = '0;
  logic [N-1:0]    grant_o, dst_valid_o;
  logic [N*DW-1:0] bwd_data_o, fwd_data_o;

  int n_tests = 0;
  int n_fail  = 0;

  bit          v_a [N];
  int          dst_a [N];
  logic [DW-1:0] fd_a [N], bd_a [N];
  int          dst_s [N];
  bit          eg [N];
  int          win [N];

  hyperbar_delta_net #(.N_PORTS(N), .DW(DW)) i_hyperbar_delta_net (
    .clk(clk), .rst_n(rst_n), .setup_i(setup_i), .release_i(release_i),
    .req_valid_i(req_valid), .req_dest_i(req_dest), .fwd_data_i(fwd_in),
    .grant_o(grant_o), .bwd_data_o(bwd_data_o), .dst_valid_o(dst_valid_o),
    .fwd_data_o(fwd_data_o), .bwd_data_i(bwd_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive();
    for (int s = 0; s < N; s++) begin
      req_valid[s] = v_a[s];
      req_dest[s*LG +: LG] = LG'(dst_a[s]);
      fwd_in[s*DW +: DW] = fd_a[s];
      bwd_in[s*DW +: DW] = bd_a[s];
    end
  endtask

  // Reference: follow each request's link position; per stage the new
  // position is (pos*2 mod N) plus the steering bit; at most two requests
  // with the lowest source indices keep each position.
  function automatic void model_setup();
    int  pos [N];
    int  np [N];
    bit  al [N];
    bit  al2 [N];
    for (int s = 0; s < N; s++) begin
      pos[s] = s; al[s] = v_a[s]; dst_s[s] = dst_a[s];
    end
    for (int st = 0; st < LG; st++) begin
      for (int s = 0; s < N; s++) np[s] = ((pos[s] << 1) & (N-1)) | ((dst_a[s] >> (LG-1-st)) & 1);
      for (int s = 0; s < N; s++) begin
        int ahead = 0;
        for (int t = 0; t < s; t++) if (al[t] && np[t] == np[s]) ahead++;
        al2[s] = al[s] && (ahead < 2);
      end
      for (int s = 0; s < N; s++) begin pos[s] = np[s]; al[s] = al2[s]; end
    end
    for (int d = 0; d < N; d++) begin
      win[d] = -1;
      for (int s = N-1; s >= 0; s--) if (al[s] && pos[s] == d) win[d] = s;
    end
    for (int s = 0; s < N; s++) eg[s] = al[s] && win[dst_a[s]] == s;
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < N; s++) begin eg[s] = 0; win[s] = -1; end
  endfunction

  task automatic verify(input string tag);
    logic [N-1:0]    xg, xv;
    logic [N*DW-1:0] xf, xb;
    xg = '0; xv = '0; xf = '0; xb = '0;
    for (int s = 0; s < N; s++) begin
      xg[s] = eg[s];
      if (eg[s]) xb[s*DW +: DW] = bd_a[dst_s[s]];
    end
    for (int d = 0; d < N; d++) if (win[d] >= 0) begin
      xv[d] = 1'b1;
      xf[d*DW +: DW] = fd_a[win[d]];
    end
    chk(grant_o == xg, {"R4 grants ", tag}, 64'(grant_o), 64'(xg));
    chk(dst_valid_o == xv, {"R5 dst_valid ", tag}, 64'(dst_valid_o), 64'(xv));
    chk(fwd_data_o == xf, {"R2 R10 fwd data ", tag}, 64'(fwd_data_o), 64'(xf));
    chk(bwd_data_o == xb, {"R3 bwd data ", tag}, 64'(bwd_data_o), 64'(xb));
  endtask

  task automatic new_data();
    for (int s = 0; s < N; s++) begin
      fd_a[s] = DW'($urandom);
      bd_a[s] = DW'($urandom);
    end
  endtask

  task automatic setup_pulse(input string tag);
    @(negedge clk);
    drive();
    setup_i = 1'b1;
    @(negedge clk);
    setup_i = 1'b0;
    model_setup();
    #1;
    verify(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    for (int s = 0; s < N; s++) begin v_a[s] = 0; dst_a[s] = 0; dst_s[s] = 0; fd_a[s] = '0; bd_a[s] = '0; end
    drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(grant_o == '0 && dst_valid_o == '0, "R1 flags after reset", 64'({grant_o, dst_valid_o}), 64'(0));
    chk(fwd_data_o == '0 && bwd_data_o == '0, "R1 data after reset", 64'(fwd_data_o ^ bwd_data_o), 64'(0));

    // identity (R2)
    new_data();
    for (int s = 0; s < N; s++) begin v_a[s] = 1; dst_a[s] = s; end
    setup_pulse("identity");
    chk(grant_o == '1, "R2 identity all granted", 64'(grant_o), 64'(8'hFF));

    // bit reversal (R2)
    new_data();
    for (int s = 0; s < N; s++) dst_a[s] = ((s & 1) << 2) | (s & 2) | ((s >> 2) & 1);
    setup_pulse("bitrev");

    // all to destination 0 (R4, R5)
    new_data();
    for (int s = 0; s < N; s++) dst_a[s] = 0;
    setup_pulse("hotspot");
    chk(grant_o == 8'h01, "R5 hotspot lowest source wins", 64'(grant_o), 64'(8'h01));

    // lone request (R2, R3)
    new_data();
    for (int s = 0; s < N; s++) v_a[s] = (s == 5);
    dst_a[5] = 2;
    setup_pulse("lone");
    chk(bwd_data_o[5*DW +: DW] == bd_a[2], "R3 lone return word", 64'(bwd_data_o[5*DW +: DW]), 64'(bd_a[2]));

    // invalid low sources aimed at a hotspot take no capacity (R9)
    new_data();
    for (int s = 0; s < N; s++) begin v_a[s] = (s >= 4); dst_a[s] = 6; end
    setup_pulse("idle-sources");
    chk(grant_o == 8'h10, "R9 idle sources ignored", 64'(grant_o), 64'(8'h10));

    // nothing valid (R10)
    for (int s = 0; s < N; s++) v_a[s] = 0;
    setup_pulse("empty");

    // random contention (R4, R5)
    for (int r = 0; r < 60; r++) begin
      bit narrow = ($urandom % 2) == 1;
      new_data();
      for (int s = 0; s < N; s++) begin
        v_a[s] = ($urandom % 4) != 0;
        dst_a[s] = narrow ? int'($urandom % 3) * 3 : int'($urandom % N);
      end
      setup_pulse("random");
      // hold: change requests and data without strobes (R7)
      if (r % 10 == 0) begin
        @(negedge clk);
        new_data();
        for (int s = 0; s < N; s++) begin v_a[s] = !v_a[s]; dst_a[s] = (dst_a[s] + 1) % N; end
        drive();
        repeat (3) @(negedge clk);
        #1;
        verify("R7 hold");
      end
    end

    // release (R8)
    @(negedge clk);
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
    model_clear();
    #1;
    verify("R8 release");

    // setup and release together: release wins (R8)
    for (int s = 0; s < N; s++) begin v_a[s] = 1; dst_a[s] = s; end
    @(negedge clk);
    drive();
    setup_i = 1'b1;
    release_i = 1'b1;
    @(negedge clk);
    setup_i = 1'b0;
    release_i = 1'b0;
    #1;
    chk(grant_o == '0 && dst_valid_o == '0, "R8 release beats setup", 64'({grant_o, dst_valid_o}), 64'(0));

    finish_run();
  end

endmodule